// File: doc/BRIEF.md
# Programmable RAS/CAS Strobe Bank Selector

This block turns a two-bit bank select and four per-byte column-strobe enables into four row-strobe (RAS) enables and four column-strobe (CAS) enables for a dynamic RAM array. A three-bit configuration code sets how the strobe lines are grouped:

- **Pairs:** the upper select bit picks a pair of lines.
- **Single row strobe:** the full select value picks one row strobe, and all column strobes are candidates.
- **Single row and column pair:** the full select value picks one matching row and column strobe.

A column strobe can only fire when its own byte enable is set.

While refresh is active, the block drives the row strobes alone. If the stagger option is off, they all rise together. If it is on, they rise in groups, one group per clock edge, in ascending line order. A group is two lines in the pair mode and one line in the single modes. The surrounding controller supplies an access-active and a refresh-active flag and keeps the code stable while programmed. The block registers every output, so outputs follow the inputs by one clock.

Top module: `strobe_bank_sel`

## Requirements
- R1: With cfg_mode = 3'b101 during an access, bank_sel[1] = 0 asserts ras_en[1:0] and bank_sel[1] = 1 asserts ras_en[3:2]. cas_en is the same pair masked by byte_en. bank_sel[0] has no effect.
- R2: With cfg_mode = 3'b110 during an access, ras_en is one-hot at bit bank_sel (00 to bit 0 through 11 to bit 3), and cas_en equals byte_en.
- R3: With cfg_mode = 3'b111 during an access, ras_en is one-hot at bit bank_sel, and cas_en is that same bit masked by byte_en.
- R4: In every mode and state, cas_en[n] is 1 only if byte_en[n] was 1 at the clock edge that loaded it.
- R5: With stagger_en = 0 and a supported mode, all four ras_en bits rise on the first edge that sees refresh_active high. They stay high while it is held and all fall on the first edge that sees it low.
- R6: With stagger_en = 1, ras_en gains one group per edge from the first refresh edge, starting at line 0 and going upward. A group is two lines in mode 101 (0011 then 1111) and one line in modes 110 and 111 (0001, 0011, 0111, 1111). ras_en then holds at 1111. A new refresh restarts from the first group.
- R7: While refresh is active, cas_en is 0 and ras_en follows the refresh pattern, even if access_active is also high in the same cycle.
- R8: Any cfg_mode other than 101, 110 or 111 drives ras_en and cas_en to 0, for both access and refresh.
- R9: Outputs are registered. They are 0 during reset, and 0 one edge after a cycle in which neither access_active nor refresh_active is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_mode | input | 3 | Strobe grouping code (101, 110, 111 valid) |
| stagger_en | input | 1 | 1 = staggered refresh, 0 = all rows together |
| bank_sel | input | 2 | Bank select for accesses |
| byte_en | input | 4 | Per-byte column strobe enables, active high |
| access_active | input | 1 | Memory access in progress |
| refresh_active | input | 1 | Refresh in progress |
| ras_en | output | 4 | Row strobe enables, active high, registered |
| cas_en | output | 4 | Column strobe enables, active high, registered |

## Verification
An access request and a refresh can arrive in the same cycle. When that happens, refresh must win: row strobes follow the refresh pattern and every column strobe stays low. The bench provokes this by keeping access_active high and all byte enables set while refresh_active rises. It then checks after each edge that cas_en stays 0 and that ras_en follows the all-together or staggered sequence. It also confirms that the access mapping comes back on the first edge after refresh drops.

// File: rtl/strobe_sel_pkg.sv
package strobe_sel_pkg;

   typedef enum logic [2:0] {
      MODE_PAIR     = 3'b101,
      MODE_RAS_ONE  = 3'b110,
      MODE_BOTH_ONE = 3'b111
   } strobe_mode_e;

   function automatic logic mode_supported(input logic [2:0] code);
      return (code == MODE_PAIR) || (code == MODE_RAS_ONE) || (code == MODE_BOTH_ONE);
   endfunction

endpackage

// File: rtl/strobe_access_decode.sv
module strobe_access_decode
   import strobe_sel_pkg::*;
#(
   parameter int unsigned N_LINES = 4,
   localparam int unsigned SEL_W  = $clog2(N_LINES)
) (
   input  logic [2:0]         mode,
   input  logic [SEL_W-1:0]   sel,
   input  logic [N_LINES-1:0] be,
   output logic [N_LINES-1:0] ras_dec,
   output logic [N_LINES-1:0] cas_dec
);

   if (N_LINES < 4 || (1 << SEL_W) != N_LINES) begin : g_bad_lines
      $error("strobe_access_decode: N_LINES must be a power of two >= 4");
   end

   for (genvar i = 0; i < N_LINES; i++) begin : g_line
      localparam logic [SEL_W-1:0] LINE_ID = SEL_W'(i);
      localparam logic [SEL_W-2:0] PAIR_ID = (SEL_W-1)'(i / 2);
      logic hit_one;
      logic hit_pair;

      assign hit_one  = (sel == LINE_ID);
      assign hit_pair = (sel[SEL_W-1:1] == PAIR_ID);

      always_comb begin
         ras_dec[i] = 1'b0;
         cas_dec[i] = 1'b0;
         case (mode)
            MODE_PAIR: begin
               ras_dec[i] = hit_pair;
               cas_dec[i] = hit_pair & be[i];
            end
            MODE_RAS_ONE: begin
               ras_dec[i] = hit_one;
               cas_dec[i] = be[i];
            end
            MODE_BOTH_ONE: begin
               ras_dec[i] = hit_one;
               cas_dec[i] = hit_one & be[i];
            end
            default: begin
               ras_dec[i] = 1'b0;
               cas_dec[i] = 1'b0;
            end
         endcase
      end
   end

endmodule

// File: rtl/strobe_refresh_seq.sv
module strobe_refresh_seq #(
   parameter int unsigned N_LINES = 4,
   localparam int unsigned STEP_W = $clog2(N_LINES),
   localparam logic [STEP_W-1:0] STEP_MAX = STEP_W'(N_LINES - 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rfsh,
   input  logic               stagger,
   input  logic               pair_groups,
   output logic [N_LINES-1:0] ras_mask
);

   logic [STEP_W-1:0] step_q;

   if (N_LINES < 4 || (1 << STEP_W) != N_LINES) begin : g_bad_lines
      $error("strobe_refresh_seq: N_LINES must be a power of two >= 4");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_q <= '0;
      end else if (!rfsh) begin
         step_q <= '0;
      end else if (step_q != STEP_MAX) begin
         step_q <= step_q + 1'b1;
      end
   end

   for (genvar i = 0; i < N_LINES; i++) begin : g_line
      localparam logic [STEP_W-1:0] GRP_ONE = STEP_W'(i);
      localparam logic [STEP_W-1:0] GRP_TWO = STEP_W'(i / 2);
      logic due;

      assign due         = pair_groups ? (GRP_TWO <= step_q) : (GRP_ONE <= step_q);
      assign ras_mask[i] = stagger ? due : 1'b1;
   end

endmodule

// File: rtl/strobe_bank_sel.sv
module strobe_bank_sel
   import strobe_sel_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] cfg_mode,
   input  logic       stagger_en,
   input  logic [1:0] bank_sel,
   input  logic [3:0] byte_en,
   input  logic       access_active,
   input  logic       refresh_active,
   output logic [3:0] ras_en,
   output logic [3:0] cas_en
);

   localparam int unsigned N_LINES = 4;

   logic [N_LINES-1:0] acc_ras;
   logic [N_LINES-1:0] acc_cas;
   logic [N_LINES-1:0] rf_ras;
   logic [N_LINES-1:0] ras_d;
   logic [N_LINES-1:0] cas_d;
   logic               mode_ok;

   strobe_access_decode #(.N_LINES(N_LINES)) u_acc_dec (
      .mode    (cfg_mode),
      .sel     (bank_sel),
      .be      (byte_en),
      .ras_dec (acc_ras),
      .cas_dec (acc_cas)
   );

   strobe_refresh_seq #(.N_LINES(N_LINES)) u_rf_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .rfsh        (refresh_active),
      .stagger     (stagger_en),
      .pair_groups (cfg_mode == MODE_PAIR),
      .ras_mask    (rf_ras)
   );

   assign mode_ok = mode_supported(cfg_mode);

   always_comb begin
      ras_d = '0;
      cas_d = '0;
      if (mode_ok) begin
         if (refresh_active) begin
            ras_d = rf_ras;
         end else if (access_active) begin
            ras_d = acc_ras;
            cas_d = acc_cas;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ras_en <= '0;
         cas_en <= '0;
      end else begin
         ras_en <= ras_d;
         cas_en <= cas_d;
      end
   end

   AST_CAS_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      (cas_en & ~$past(byte_en)) == 4'b0000); // R4

   AST_RFSH_NO_CAS: assert property (@(posedge clk) disable iff (!rst_n)
      $past(refresh_active) |-> (cas_en == 4'b0000)); // R7

   AST_BAD_MODE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_supported($past(cfg_mode)) |-> (ras_en == 4'b0000 && cas_en == 4'b0000)); // R8

   AST_PAIR_TWO_RAS: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(access_active) && !$past(refresh_active) && $past(cfg_mode) == MODE_PAIR)
      |-> ($countones(ras_en) == 2)); // R1

   AST_SINGLE_RAS: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(access_active) && !$past(refresh_active) && $past(cfg_mode[2:1]) == 2'b11)
      |-> ($countones(ras_en) == 1)); // R3

   AST_STAGGER_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(refresh_active) && $past(refresh_active, 2) &&
       $past(cfg_mode) == $past(cfg_mode, 2) && $past(stagger_en) == $past(stagger_en, 2))
      |-> (($past(ras_en) & ~ras_en) == 4'b0000)); // R6

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(access_active) && !$past(refresh_active)) |-> (ras_en == 4'b0000)); // R9

endmodule

// File: tb/strobe_bank_sel_tb_top.sv
module strobe_bank_sel_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] cfg_mode = 3'b000;
   logic       stagger_en = 1'b0;
   logic [1:0] bank_sel = 2'b00;
   logic [3:0] byte_en = 4'b0000;
   logic       access_active = 1'b0;
   logic       refresh_active = 1'b0;
   logic [3:0] ras_en;
   logic [3:0] cas_en;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #10 clk = ~clk;

   strobe_bank_sel dut_i (
      .clk            (clk),
      .rst_n          (rst_n),
      .cfg_mode       (cfg_mode),
      .stagger_en     (stagger_en),
      .bank_sel       (bank_sel),
      .byte_en        (byte_en),
      .access_active  (access_active),
      .refresh_active (refresh_active),
      .ras_en         (ras_en),
      .cas_en         (cas_en)
   );

   // {mode, sel, byte_en, expected ras, expected cas}
   localparam int NVEC = 13;
   localparam logic [16:0] VEC [NVEC] = '{
      {3'b101, 2'b00, 4'b1111, 4'b0011, 4'b0011},  // R1
      {3'b101, 2'b01, 4'b1111, 4'b0011, 4'b0011},  // R1 low select bit ignored
      {3'b101, 2'b10, 4'b1111, 4'b1100, 4'b1100},  // R1
      {3'b101, 2'b11, 4'b0100, 4'b1100, 4'b0100},  // R1 R4
      {3'b110, 2'b00, 4'b1111, 4'b0001, 4'b1111},  // R2
      {3'b110, 2'b10, 4'b1010, 4'b0100, 4'b1010},  // R2 R4
      {3'b110, 2'b11, 4'b0000, 4'b1000, 4'b0000},  // R2 R4
      {3'b111, 2'b00, 4'b1111, 4'b0001, 4'b0001},  // R3
      {3'b111, 2'b01, 4'b1111, 4'b0010, 4'b0010},  // R3
      {3'b111, 2'b10, 4'b1011, 4'b0100, 4'b0000},  // R3 R4
      {3'b111, 2'b11, 4'b1000, 4'b1000, 4'b1000},  // R3
      {3'b011, 2'b01, 4'b1111, 4'b0000, 4'b0000},  // R8
      {3'b000, 2'b00, 4'b1111, 4'b0000, 4'b0000}   // R8
   };

   task automatic chk(input string req, input logic [3:0] got, input logic [3:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %b expected %b", req, got, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #2;
   endtask

   task automatic refresh_seq(input string req, input logic [2:0] mode, input logic stg,
                              input logic [3:0] e0, input logic [3:0] e1,
                              input logic [3:0] e2, input logic [3:0] e3);
      @(negedge clk);
      cfg_mode = mode; stagger_en = stg;
      access_active = 1'b1; byte_en = 4'b1111; bank_sel = 2'b10;
      refresh_active = 1'b1;
      step(); chk({req, " step0 ras"}, ras_en, e0); chk("R7 cas during refresh", cas_en, 4'b0000);
      step(); chk({req, " step1 ras"}, ras_en, e1);
      step(); chk({req, " step2 ras"}, ras_en, e2);
      step(); chk({req, " step3 ras"}, ras_en, e3); chk("R7 cas during refresh", cas_en, 4'b0000);
      step(); chk({req, " hold ras"}, ras_en, e3);
      @(negedge clk);
      refresh_active = 1'b0; access_active = 1'b0;
      step(); chk({req, " end ras"}, ras_en, 4'b0000);
   endtask

   initial begin
      #5;
      chk("R9 reset ras", ras_en, 4'b0000);
      chk("R9 reset cas", cas_en, 4'b0000);
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      for (int k = 0; k < NVEC; k++) begin
         @(negedge clk);
         cfg_mode = VEC[k][16:14]; bank_sel = VEC[k][13:12]; byte_en = VEC[k][11:8];
         access_active = 1'b1;
         step();
         chk($sformatf("R1/R2/R3/R8 vec%0d ras", k), ras_en, VEC[k][7:4]);
         chk($sformatf("R4/R8 vec%0d cas", k), cas_en, VEC[k][3:0]);
      end

      // R9: no activity
      @(negedge clk);
      cfg_mode = 3'b111; access_active = 1'b0;
      step(); chk("R9 idle ras", ras_en, 4'b0000); chk("R9 idle cas", cas_en, 4'b0000);

      // R5 all together, access overlapping (R7)
      refresh_seq("R5 mode110", 3'b110, 1'b0, 4'b1111, 4'b1111, 4'b1111, 4'b1111);
      refresh_seq("R5 mode101", 3'b101, 1'b0, 4'b1111, 4'b1111, 4'b1111, 4'b1111);
      // R6 staggered
      refresh_seq("R6 mode111", 3'b111, 1'b1, 4'b0001, 4'b0011, 4'b0111, 4'b1111);
      refresh_seq("R6 mode110", 3'b110, 1'b1, 4'b0001, 4'b0011, 4'b0111, 4'b1111);
      refresh_seq("R6 mode101", 3'b101, 1'b1, 4'b0011, 4'b1111, 4'b1111, 4'b1111);
      // R6 restart after refresh ends
      refresh_seq("R6 restart", 3'b111, 1'b1, 4'b0001, 4'b0011, 4'b0111, 4'b1111);
      // R8 refresh in an unsupported mode
      refresh_seq("R8 mode100", 3'b100, 1'b0, 4'b0000, 4'b0000, 4'b0000, 4'b0000);

      // R7: access mapping returns right after refresh drops
      @(negedge clk);
      cfg_mode = 3'b111; stagger_en = 1'b0; bank_sel = 2'b01; byte_en = 4'b1111;
      access_active = 1'b1; refresh_active = 1'b1;
      step(); chk("R7 overlap ras", ras_en, 4'b1111); chk("R7 overlap cas", cas_en, 4'b0000);
      @(negedge clk);
      refresh_active = 1'b0;
      step(); chk("R7 after refresh ras", ras_en, 4'b0010); chk("R7 after refresh cas", cas_en, 4'b0010);

      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            n_checks++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
         end
      join_any
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule